// File: doc/BRIEF.md
# Supply-Pulse Trim Programming Decoder

This block sits behind the level detector on a two-wire sensor's supply pin and turns a train of supply-level pulses into calibration writes. Each clock it receives a two-bit code giving the present supply level (zero, low hold, mid, high). It times how many cycles each level lasts and sorts every mid or high pulse into noise, short or long. A keying sequence has to arrive before anything is written. After that the number of mid pulses selects a bitfield address. The pulse that closes the address count then decides the action. A short high pulse writes a trial calibration value. A long high pulse fires a fuse-blow strobe for one bitfield.

The block keeps a volatile trial register and a set of emulated one-time fuse bits: five data bits and one lock bit. Its output is the effective 5-bit trim code, which is the OR of the blown data fuses and the trial value, together with a lock flag. Once the lock fuse is blown, no further coding sequence is accepted.

Top module: `trim_pulse_decoder`

## Requirements
- R1: After reset `trim_o` is 0, `locked_o` is 0 and `blow_stb_o` is low.
- R2: `lvl_i` encodes 0 = zero, 1 = low hold, 2 = mid, 3 = high. A pulse's length is the number of clock edges at which its level is sampled. A mid or high pulse shorter than `SHORT_MIN` cycles is noise and returns the decoder to idle. A pulse of `SHORT_MIN` up to `LONG_MIN`-1 cycles is short. A pulse of `LONG_MIN` or more cycles is long.
- R3: Coding unlocks only after the ordered pulses short high, non-noise mid, short high, with low gaps in between. A pulse out of that order abandons the sequence and changes no register.
- R4: After unlock, the address is the count of mid pulses that follow. A short high pulse after a count k of 1..31 loads k into the trial register. `trim_o` equals the blown data fuses ORed with the trial register, and it is updated within two cycles of the end of that high pulse.
- R5: A count past 32, or a short high pulse after a count of 32, abandons the sequence with no register change.
- R6: A zero level clears the trial register and the sequence. Blown fuses are kept.
- R7: A long high pulse after a count k of 1..5 produces a strobe on `blow_stb_o` that lasts exactly one cycle, with `blow_idx_o` = k-1. The next cycle sets that fuse, which adds weight 2^(k-1) to `trim_o`. A long high pulse after a count of 6..31 gives no strobe.
- R8: A long high pulse after a count of 32 strobes with `blow_idx_o` = 5 and sets the lock fuse. From then on `locked_o` is 1 and the trial register reads zero.
- R9: While locked, every keying sequence is ignored: no trial load and no strobe.
- R10: A blown fuse bit never clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| lvl_i | input | 2 | Sampled supply level code |
| trim_o | output | TRIM_W (5) | Effective calibration code |
| locked_o | output | 1 | Lock fuse blown |
| blow_stb_o | output | 1 | One-cycle fuse-blow strobe |
| blow_idx_o | output | 3 | Bit index to blow (0..4 data, 5 lock) |

## Verification
The bench aims at pulse widths that sit exactly on `SHORT_MIN`, one cycle below it, and on `LONG_MIN`. An off-by-one counter would make a valid key fail, or let a noise spike count as a pulse. It sends keys with the wrong order and a long first pulse, and a count of 33. A decoder that does not abandon these cases would write a trial value. It blows addresses 3 and 1, then an out-of-range 7, and checks the strobe count and index. This catches a strobe held two cycles, a wrong weight mapping, or a blow at an illegal address. It locks the part while a trial value is active and then retries coding. A design that left the trial value in place or still honoured the key after locking would show a wrong trim or an extra strobe.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    LV_ZERO = 2'd0,
    LV_LOW  = 2'd1,
    LV_MID  = 2'd2,
    LV_HIGH = 2'd3
  } level_e;

  typedef enum logic [1:0] {
    DUR_NOISE = 2'd0,
    DUR_SHORT = 2'd1,
    DUR_LONG  = 2'd2
  } dur_e;

  // Pulse length class from a cycle count.
  function automatic dur_e classify_len(int len, int short_min, int long_min);
    if (len < short_min) return DUR_NOISE;
    if (len < long_min)  return DUR_SHORT;
    return DUR_LONG;
  endfunction

  // Addresses that may be blown: data bits 1..w and the lock address 2**w.
  function automatic logic blow_addr_ok(int k, int w);
    return ((k >= 1) && (k <= w)) || (k == (1 << w));
  endfunction

  // Fuse index for a blowable address: data k -> k-1, lock -> w.
  function automatic int blow_bit(int k, int w);
    return (k == (1 << w)) ? w : k - 1;
  endfunction

endpackage

// File: rtl/trim_pulse_meter.sv
module trim_pulse_meter
  import trim_pkg::*;
#(
  parameter int SHORT_MIN = 5,
  parameter int LONG_MIN  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_i,
  output logic       seg_end_o,
  output level_e     seg_lvl_o,
  output dur_e       seg_dur_o,
  output logic       zero_o
);
  localparam int CNT_W = $clog2(LONG_MIN + 1);

  level_e             lvl_now;
  level_e             lvl_q;
  logic [CNT_W-1:0]   len_q;

  assign lvl_now = level_e'(lvl_i);

  // len_q = number of edges at which lvl_q has been sampled (saturating).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LV_ZERO;
      len_q <= '0;
    end else if (lvl_now != lvl_q) begin
      lvl_q <= lvl_now;
      len_q <= CNT_W'(1);
    end else if (len_q != '1) begin
      len_q <= len_q + 1'b1;
    end
  end

  assign seg_end_o = (lvl_now != lvl_q);
  assign seg_lvl_o = lvl_q;
  assign seg_dur_o = classify_len(int'(len_q), SHORT_MIN, LONG_MIN);
  assign zero_o    = (lvl_now == LV_ZERO);

endmodule

// File: rtl/trim_proto_fsm.sv
module trim_proto_fsm
  import trim_pkg::*;
#(
  parameter  int TRIM_W = 5,
  localparam int IDX_W  = $clog2(TRIM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_end_i,
  input  level_e            seg_lvl_i,
  input  dur_e              seg_dur_i,
  input  logic              zero_i,
  input  logic              locked_i,
  output logic              trial_ld_o,
  output logic [TRIM_W-1:0] trial_val_o,
  output logic              blow_stb_o,
  output logic [IDX_W-1:0]  blow_idx_o
);
  localparam int LOCK_ADDR = 1 << TRIM_W;
  localparam int ADR_W     = TRIM_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_KEY1, S_KEY2, S_ARMED, S_COUNT} st_e;

  st_e               st_q, st_d;
  logic [ADR_W-1:0]  adr_q, adr_d;
  logic              ld_d, stb_d;
  logic [TRIM_W-1:0] val_d;
  logic [IDX_W-1:0]  idx_d;
  logic              at_lock;

  assign at_lock = (adr_q == ADR_W'(LOCK_ADDR));

  always_comb begin
    st_d  = st_q;
    adr_d = adr_q;
    ld_d  = 1'b0;
    val_d = '0;
    stb_d = 1'b0;
    idx_d = '0;
    if (zero_i) begin
      st_d  = S_IDLE;
      adr_d = '0;
    end else if (seg_end_i && (seg_lvl_i inside {LV_MID, LV_HIGH})) begin
      if (seg_dur_i == DUR_NOISE) begin
        st_d = S_IDLE;
      end else if (seg_lvl_i == LV_MID) begin
        case (st_q)
          S_KEY1:  st_d = S_KEY2;
          S_ARMED: begin st_d = S_COUNT; adr_d = ADR_W'(1); end
          S_COUNT: begin
            if (at_lock) st_d = S_IDLE;
            else         adr_d = adr_q + 1'b1;
          end
          default: st_d = S_IDLE;
        endcase
      end else begin
        case (st_q)
          S_IDLE: if (seg_dur_i == DUR_SHORT && !locked_i) st_d = S_KEY1;
          S_KEY2: begin
            st_d  = (seg_dur_i == DUR_SHORT) ? S_ARMED : S_IDLE;
            adr_d = '0;
          end
          S_COUNT: begin
            st_d = S_IDLE;
            if (seg_dur_i == DUR_SHORT && !at_lock) begin
              ld_d  = 1'b1;
              val_d = adr_q[TRIM_W-1:0];
            end else if (seg_dur_i == DUR_LONG && blow_addr_ok(int'(adr_q), TRIM_W)) begin
              stb_d = 1'b1;
              idx_d = IDX_W'(blow_bit(int'(adr_q), TRIM_W));
            end
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      adr_q       <= '0;
      trial_ld_o  <= 1'b0;
      trial_val_o <= '0;
      blow_stb_o  <= 1'b0;
      blow_idx_o  <= '0;
    end else begin
      st_q        <= st_d;
      adr_q       <= adr_d;
      trial_ld_o  <= ld_d;
      trial_val_o <= val_d;
      blow_stb_o  <= stb_d;
      blow_idx_o  <= idx_d;
    end
  end

  // R9: a locked part never leaves idle
  a_r9_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    locked_i |-> st_q == S_IDLE);
  // R6: zero level abandons any sequence
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> st_q == S_IDLE);
  // R7: strobe lasts a single cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    blow_stb_o |=> !blow_stb_o);
  // R5: address counter never passes the lock address
  a_r5_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    adr_q <= ADR_W'(LOCK_ADDR));
  // R4: a trial load always carries a nonzero count
  a_r4_trial_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    trial_ld_o |-> trial_val_o != '0);
  // R7: strobe index is a data bit or the lock bit
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    blow_stb_o |-> blow_idx_o <= IDX_W'(TRIM_W));

endmodule

// File: rtl/trim_fuse_bank.sv
module trim_fuse_bank #(
  parameter  int TRIM_W = 5,
  localparam int IDX_W  = $clog2(TRIM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_i,
  input  logic              trial_ld_i,
  input  logic [TRIM_W-1:0] trial_val_i,
  input  logic              blow_stb_i,
  input  logic [IDX_W-1:0]  blow_idx_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              locked_o
);
  logic [TRIM_W:0]   fuse_q;
  logic [TRIM_W:0]   hit;
  logic [TRIM_W-1:0] trial_q;

  for (genvar i = 0; i <= TRIM_W; i++) begin : g_hit
    assign hit[i] = blow_stb_i && (blow_idx_i == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fuse_q <= '0;
    else        fuse_q <= fuse_q | hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  trial_q <= '0;
    else if (zero_i || hit[TRIM_W] || fuse_q[TRIM_W]) trial_q <= '0;
    else if (trial_ld_i)                         trial_q <= trial_val_i;
  end

  assign trim_o   = fuse_q[TRIM_W-1:0] | trial_q;
  assign locked_o = fuse_q[TRIM_W];

  // R10: no fuse bit ever falls
  a_r10_fuse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fuse_q) & ~fuse_q) == '0);
  // R8: a locked part holds no trial value
  a_r8_lock_no_trial: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> trial_q == '0);
  // R6: zero level empties the trial register
  a_r6_zero_trial: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> trial_q == '0);

endmodule

// File: rtl/trim_pulse_decoder.sv
module trim_pulse_decoder
  import trim_pkg::*;
#(
  parameter  int TRIM_W    = 5,
  parameter  int SHORT_MIN = 5,
  parameter  int LONG_MIN  = 25,
  localparam int IDX_W     = $clog2(TRIM_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lvl_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              locked_o,
  output logic              blow_stb_o,
  output logic [IDX_W-1:0]  blow_idx_o
);
  logic              seg_end;
  level_e            seg_lvl;
  dur_e              seg_dur;
  logic              zero_lvl;
  logic              trial_ld;
  logic [TRIM_W-1:0] trial_val;

  trim_pulse_meter #(.SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN)) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i),
    .seg_end_o(seg_end), .seg_lvl_o(seg_lvl), .seg_dur_o(seg_dur), .zero_o(zero_lvl)
  );

  trim_proto_fsm #(.TRIM_W(TRIM_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .seg_end_i(seg_end), .seg_lvl_i(seg_lvl), .seg_dur_i(seg_dur),
    .zero_i(zero_lvl), .locked_i(locked_o),
    .trial_ld_o(trial_ld), .trial_val_o(trial_val),
    .blow_stb_o(blow_stb_o), .blow_idx_o(blow_idx_o)
  );

  trim_fuse_bank #(.TRIM_W(TRIM_W)) u_fuse (
    .clk(clk), .rst_n(rst_n), .zero_i(zero_lvl),
    .trial_ld_i(trial_ld), .trial_val_i(trial_val),
    .blow_stb_i(blow_stb_o), .blow_idx_i(blow_idx_o),
    .trim_o(trim_o), .locked_o(locked_o)
  );

endmodule

// File: tb/trim_pulse_decoder_bench.sv
`timescale 1ns/1ps
module trim_pulse_decoder_bench;
  localparam int SMIN = 5;
  localparam int LMIN = 25;
  localparam int S = 8;
  localparam int L = 40;
  localparam int G = 8;
  localparam logic [1:0] ZERO = 2'd0, LOW = 2'd1, MID = 2'd2, HIGH = 2'd3;

  localparam int NV = 6;
  localparam int VK [NV] = '{1, 5, 17, 31, 0, 33};
  localparam int VE [NV] = '{1, 5, 17, 31, 0, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lvl_i = ZERO;
  logic [4:0] trim_o;
  logic       locked_o;
  logic       blow_stb_o;
  logic [2:0] blow_idx_o;

  int errors = 0;
  int checks = 0;
  int stb_n = 0;
  int last_idx = -1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trim_pulse_decoder u_trim_pulse_decoder (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i),
    .trim_o(trim_o), .locked_o(locked_o),
    .blow_stb_o(blow_stb_o), .blow_idx_o(blow_idx_o)
  );

  always @(negedge clk) begin
    if (rst_n && blow_stb_o) begin
      stb_n++;
      last_idx = int'(blow_idx_o);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] v, input int n);
    lvl_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic key(input int w);
    hold(HIGH, w); hold(LOW, G);
    hold(MID, w);  hold(LOW, G);
    hold(HIGH, w); hold(LOW, G);
  endtask

  task automatic addr(input int k, input int w);
    for (int j = 0; j < k; j++) begin
      hold(MID, w); hold(LOW, G);
    end
  endtask

  task automatic trial(input int k, input int w, input int hw);
    key(w); addr(k, w); hold(HIGH, hw); hold(LOW, G);
  endtask

  task automatic blow(input int k, input int hw);
    key(S); addr(k, S); hold(HIGH, hw); hold(LOW, G);
  endtask

  task automatic clear();
    hold(ZERO, 4); hold(LOW, 4);
  endtask

  initial begin
    int pre;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 trim", int'(trim_o), 0);
    check("R1 locked", int'(locked_o), 0);
    check("R1 strobe", int'(blow_stb_o), 0);
    hold(LOW, 4);

    // Trial table: count -> expected trim
    for (int i = 0; i < NV; i++) begin
      trial(VK[i], S, S);
      check((VK[i] > 32) ? "R5 over-count" : "R4 trial", int'(trim_o), VE[i]);
      clear();
    end

    // R2 boundary: pulses exactly SHORT_MIN, closing high LONG_MIN-1 is still short
    trial(6, SMIN, LMIN - 1);
    check("R2 min-width key", int'(trim_o), 6);
    clear();
    // R2 noise high inside key
    hold(HIGH, S); hold(LOW, G); hold(MID, S); hold(LOW, G);
    hold(HIGH, SMIN - 1); hold(LOW, G);
    addr(4, S); hold(HIGH, S); hold(LOW, G);
    check("R2 noise abort", int'(trim_o), 0);
    clear();

    // R3 wrong order: high, high, mid...
    hold(HIGH, S); hold(LOW, G); hold(HIGH, S); hold(LOW, G);
    addr(3, S); hold(HIGH, S); hold(LOW, G);
    check("R3 wrong order", int'(trim_o), 0);
    clear();
    // R3 long first high
    hold(HIGH, L); hold(LOW, G); hold(MID, S); hold(LOW, G);
    hold(HIGH, S); hold(LOW, G); addr(3, S); hold(HIGH, S); hold(LOW, G);
    check("R3 long key", int'(trim_o), 0);
    clear();

    // R6 zero clears trial
    trial(9, S, S);
    check("R6 before zero", int'(trim_o), 9);
    clear();
    check("R6 after zero", int'(trim_o), 0);

    // R7 blow address 3 -> bit 2, exactly LONG_MIN high
    pre = stb_n;
    blow(3, LMIN);
    check("R7 strobe count", stb_n - pre, 1);
    check("R7 strobe idx", last_idx, 2);
    clear();
    check("R7 fuse weight 4", int'(trim_o), 4);
    pre = stb_n;
    blow(1, L);
    check("R7 strobe idx", last_idx, 0);
    check("R7 strobe count", stb_n - pre, 1);
    clear();
    check("R10 fuses kept", int'(trim_o), 5);

    // R4 OR of fuses and trial
    trial(2, S, S);
    check("R4 or", int'(trim_o), 7);
    clear();

    // R7 address 7 not blowable
    pre = stb_n;
    blow(7, L);
    check("R7 no strobe at 7", stb_n - pre, 0);
    clear();
    check("R7 trim unchanged", int'(trim_o), 5);

    // R8 lock while trial active
    trial(10, S, S);
    check("R8 trial before lock", int'(trim_o), 15);
    pre = stb_n;
    blow(32, L);
    check("R8 strobe count", stb_n - pre, 1);
    check("R8 strobe idx", last_idx, 5);
    check("R8 locked", int'(locked_o), 1);
    check("R8 trial dropped", int'(trim_o), 5);

    // R9 locked ignores coding
    trial(8, S, S);
    check("R9 trial ignored", int'(trim_o), 5);
    pre = stb_n;
    blow(2, L);
    check("R9 blow ignored", stb_n - pre, 0);
    clear();
    check("R10 after zero trim", int'(trim_o), 5);
    check("R10 after zero lock", int'(locked_o), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule